// File: doc/BRIEF.md
# Event Counter Bank with Threshold Interrupts

This block holds a bank of profiling counters for a processor core. Each counter picks one of many condition strobes, such as cycles, retired instructions or cache misses. There are more strobes than counters. While a counter is enabled, it adds one on every clock in which its chosen strobe is high. Each counter can skip events that occur in user mode, in kernel mode, or in neither.

Software loads a start value and a limit value into each counter through a simple word-addressed register port. When an increment brings a counter to its limit, the counter sets a sticky pending flag and keeps counting, so software can later see how far it ran past the threshold. The single interrupt line is the OR of all pending flags whose enable bits are set. Software takes the line down by writing ones to clear every pending flag. A snapshot register copies one counter's full value in a single write, so the two halves read back consistently.

Registers are 32-bit words. Global registers: 0x000 configuration (read only: bits 7:0 counter count, 15:8 counter width, 31:16 condition count); 0x001 snapshot index (a write copies that counter into the snapshot); 0x002 and 0x003 snapshot low and high; 0x004 pending flags (bit i for counter i, write one to clear); 0x005 interrupt enable (bit i for counter i). Counter i starts at 0x020 + 8*i, with these offsets: +0 control (bit 0 enable, bit 1 skip user-mode events, bit 2 skip kernel-mode events, bits 15:8 condition number); +1 and +2 count low and high; +3 and +4 limit low and high.

Top module: `evc_bank`

## Requirements
- R1: After reset, all counts, limits, controls, pending flags and interrupt enables are zero, and irq_o is low.
- R2: An enabled counter adds exactly one on each clock edge where its selected condition bit of cond_i is high. Other condition bits, or a clear enable bit (control bit 0), leave it unchanged.
- R3: Writing the count low or high word loads that half of the counter at the next edge. A count write in the same cycle as an event takes priority, and the event is dropped.
- R4: When an increment makes a counter equal to its limit, its pending bit (bit i of 0x004) is set at that same edge. The counter keeps incrementing past the limit.
- R5: A pending bit stays set until software writes 1 to that bit of 0x004. Writing 0 has no effect. A new limit hit in the same cycle as its clear leaves the bit set.
- R6: irq_o is high exactly when some counter has both its pending bit and its enable bit (bit i of 0x005) set.
- R7: With control bit 1 set, events are ignored while user_mode_i is 1. With control bit 2 set, events are ignored while user_mode_i is 0.
- R8: Writing a counter number to 0x001 copies that counter's value into the snapshot. Words 0x002 and 0x003 return the low 32 bits and the upper bits, and they do not change while the counter keeps running.
- R9: Configuration word 0x000 reads {NUM_COND[15:0], CNT_W[7:0], NUM_CNT[7:0]}.
- R10: Counting carries from the low word into the high word and wraps to zero past 2^CNT_W - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 10 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 10 | Register read word address |
| rd_data_o | output | 32 | Register read data (combinational) |
| cond_i | input | NUM_COND | Countable condition strobes |
| user_mode_i | input | 1 | 1 while the core runs in user mode |
| irq_o | output | 1 | OR of enabled pending flags |

## Verification
The counting function is exercised with single event pulses, bursts on the selected condition, events on a condition that is not selected, and events with the enable bit clear. Together these separate selection faults from faults in the enable gate. Limit crossing is driven step by step just below, at and past the limit, which shows both the flag timing and that counting continues. Both mode filters are driven in both modes, which distinguishes a swapped filter from a missing one. Writes that collide with events or with limit hits, carries across the low word, and wrap at the full width cover the priority and boundary cases.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int CTRL_W = 16;
  // global register offsets (block 0)
  localparam logic [2:0] G_CFG   = 3'd0;
  localparam logic [2:0] G_SIDX  = 3'd1;
  localparam logic [2:0] G_SLO   = 3'd2;
  localparam logic [2:0] G_SHI   = 3'd3;
  localparam logic [2:0] G_PEND  = 3'd4;
  localparam logic [2:0] G_IRQEN = 3'd5;
  // per counter offsets
  localparam logic [2:0] C_CTRL  = 3'd0;
  localparam logic [2:0] C_CLO   = 3'd1;
  localparam logic [2:0] C_CHI   = 3'd2;
  localparam logic [2:0] C_LLO   = 3'd3;
  localparam logic [2:0] C_LHI   = 3'd4;
  localparam int CNT_BLK0 = 4;  // counter 0 at 0x020
  // control bits
  localparam int B_EN     = 0;
  localparam int B_NOUSER = 1;
  localparam int B_NOKERN = 2;
  localparam int B_SEL    = 8;
endpackage

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
#(
  parameter int CNT_W    = 48,
  parameter int NUM_COND = 120
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_ctrl_i,
  input  logic                wr_clo_i,
  input  logic                wr_chi_i,
  input  logic                wr_llo_i,
  input  logic                wr_lhi_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [NUM_COND-1:0] cond_i,
  input  logic                user_mode_i,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [CNT_W-1:0]    lim_o,
  output logic                inc_o,
  output logic                hit_o
);
  localparam int SEL_W = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d, lim_q, lim_d, cnt_inc;
  logic [63:0]       cnt_ext, lim_ext, cnt_wr, lim_wr;
  logic [7:0]        sel;
  logic              cond_sel, blocked, inc;

  assign sel = ctrl_q[B_SEL +: 8];
  assign cond_sel = (32'(sel) < NUM_COND) ? cond_i[sel[SEL_W-1:0]] : 1'b0;
  assign blocked  = (user_mode_i & ctrl_q[B_NOUSER]) | (~user_mode_i & ctrl_q[B_NOKERN]);
  assign inc      = ctrl_q[B_EN] & cond_sel & ~blocked & ~wr_clo_i & ~wr_chi_i;
  assign cnt_inc  = cnt_q + CNT_W'(1);

  assign cnt_ext = 64'(cnt_q);
  assign lim_ext = 64'(lim_q);
  assign cnt_wr  = wr_clo_i ? {cnt_ext[63:32], wr_data_i} : {wr_data_i, cnt_ext[31:0]};
  assign lim_wr  = wr_llo_i ? {lim_ext[63:32], wr_data_i} : {wr_data_i, lim_ext[31:0]};

  always_comb begin
    cnt_d = cnt_q;
    if (wr_clo_i || wr_chi_i) cnt_d = cnt_wr[CNT_W-1:0];
    else if (inc)             cnt_d = cnt_inc;
    lim_d = lim_q;
    if (wr_llo_i || wr_lhi_i) lim_d = lim_wr[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else begin
      if (wr_ctrl_i) ctrl_q <= wr_data_i[CTRL_W-1:0];
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign cnt_o  = cnt_q;
  assign lim_o  = lim_q;
  assign inc_o  = inc;
  assign hit_o  = inc && (cnt_inc == lim_q);
endmodule

// File: rtl/evc_rd_mux.sv
module evc_rd_mux
  import evc_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 48
) (
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  input  logic [DATA_W-1:0]                 cfg_i,
  input  logic [7:0]                        snap_idx_i,
  input  logic [CNT_W-1:0]                  snap_i,
  input  logic [NUM_CNT-1:0]                pend_i,
  input  logic [NUM_CNT-1:0]                irq_en_i,
  input  logic [NUM_CNT-1:0][CTRL_W-1:0]    ctrl_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]     lim_i,
  output logic [DATA_W-1:0]                 rd_data_o
);
  logic [ADDR_W-4:0] blk;
  logic [2:0]        off;
  logic [63:0]       snap_ext;

  assign blk = rd_addr_i[ADDR_W-1:3];
  assign off = rd_addr_i[2:0];
  assign snap_ext = 64'(snap_i);

  always_comb begin
    logic [63:0] c_ext, l_ext;
    rd_data_o = '0;
    if (blk == '0) begin
      case (off)
        G_CFG:   rd_data_o = cfg_i;
        G_SIDX:  rd_data_o = 32'(snap_idx_i);
        G_SLO:   rd_data_o = snap_ext[31:0];
        G_SHI:   rd_data_o = snap_ext[63:32];
        G_PEND:  rd_data_o = 32'(pend_i);
        G_IRQEN: rd_data_o = 32'(irq_en_i);
        default: rd_data_o = '0;
      endcase
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      c_ext = 64'(cnt_i[i]);
      l_ext = 64'(lim_i[i]);
      if (blk == (ADDR_W-3)'(CNT_BLK0 + i)) begin
        case (off)
          C_CTRL:  rd_data_o = 32'(ctrl_i[i]);
          C_CLO:   rd_data_o = c_ext[31:0];
          C_CHI:   rd_data_o = c_ext[63:32];
          C_LLO:   rd_data_o = l_ext[31:0];
          C_LHI:   rd_data_o = l_ext[63:32];
          default: rd_data_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int NUM_CNT  = 4,
  parameter int CNT_W    = 48,
  parameter int NUM_COND = 120
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [NUM_COND-1:0] cond_i,
  input  logic                user_mode_i,
  output logic                irq_o
);
  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam logic [DATA_W-1:0] CFG_WORD = {16'(NUM_COND), 8'(CNT_W), 8'(NUM_CNT)};

  logic [NUM_CNT-1:0][CTRL_W-1:0] ctrl_arr;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_arr, lim_arr;
  logic [NUM_CNT-1:0]             inc_vec, hit_vec;
  logic [NUM_CNT-1:0]             pend_q, irq_en_q, pend_clr;
  logic [CNT_W-1:0]               snap_q;
  logic [7:0]                     snap_idx_q;
  logic [ADDR_W-4:0]              wr_blk;
  logic [2:0]                     wr_off;
  logic                           glb_wr;

  assign wr_blk = wr_addr_i[ADDR_W-1:3];
  assign wr_off = wr_addr_i[2:0];
  assign glb_wr = wr_en_i && (wr_blk == '0);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic sel_w;
    assign sel_w = wr_en_i && (wr_blk == (ADDR_W-3)'(CNT_BLK0 + g));
    evc_counter #(.CNT_W(CNT_W), .NUM_COND(NUM_COND)) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_ctrl_i   (sel_w && wr_off == C_CTRL),
      .wr_clo_i    (sel_w && wr_off == C_CLO),
      .wr_chi_i    (sel_w && wr_off == C_CHI),
      .wr_llo_i    (sel_w && wr_off == C_LLO),
      .wr_lhi_i    (sel_w && wr_off == C_LHI),
      .wr_data_i   (wr_data_i),
      .cond_i      (cond_i),
      .user_mode_i (user_mode_i),
      .ctrl_o      (ctrl_arr[g]),
      .cnt_o       (cnt_arr[g]),
      .lim_o       (lim_arr[g]),
      .inc_o       (inc_vec[g]),
      .hit_o       (hit_vec[g])
    );
  end

  assign pend_clr = (glb_wr && wr_off == G_PEND) ? wr_data_i[NUM_CNT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      irq_en_q   <= '0;
      snap_q     <= '0;
      snap_idx_q <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr) | hit_vec;  // set beats clear
      if (glb_wr && wr_off == G_IRQEN) irq_en_q <= wr_data_i[NUM_CNT-1:0];
      if (glb_wr && wr_off == G_SIDX) begin
        snap_idx_q <= wr_data_i[7:0];
        snap_q <= (wr_data_i < NUM_CNT) ? cnt_arr[wr_data_i[IDX_W-1:0]] : '0;
      end
    end
  end

  assign irq_o = |(pend_q & irq_en_q);

  evc_rd_mux #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_rd (
    .rd_addr_i  (rd_addr_i),
    .cfg_i      (CFG_WORD),
    .snap_idx_i (snap_idx_q),
    .snap_i     (snap_q),
    .pend_i     (pend_q),
    .irq_en_i   (irq_en_q),
    .ctrl_i     (ctrl_arr),
    .cnt_i      (cnt_arr),
    .lim_i      (lim_arr),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk
  import evc_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 48
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   wr_addr_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic                user_mode_i,
  input logic                irq_o,
  input logic [NUM_CNT-1:0]  pend_q,
  input logic [NUM_CNT-1:0]  hit_vec,
  input logic [NUM_CNT-1:0]  inc_vec,
  input logic [CTRL_W-1:0]   ctrl0,
  input logic [CNT_W-1:0]    cnt0,
  input logic [CNT_W-1:0]    snap_q
);
  logic cnt0_wr, pend_wr, sidx0_wr;
  logic [NUM_CNT-1:0] clr_m;
  assign cnt0_wr  = wr_en_i && wr_addr_i[ADDR_W-1:3] == (ADDR_W-3)'(CNT_BLK0)
                    && (wr_addr_i[2:0] == C_CLO || wr_addr_i[2:0] == C_CHI);
  assign pend_wr  = wr_en_i && wr_addr_i == ADDR_W'(G_PEND);
  assign sidx0_wr = wr_en_i && wr_addr_i == ADDR_W'(G_SIDX) && wr_data_i == '0;
  assign clr_m    = pend_wr ? wr_data_i[NUM_CNT-1:0] : '0;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_vec[0] |=> cnt0 == $past(cnt0) + CNT_W'(1));
  p_off_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl0[B_EN] && !cnt0_wr) |=> $stable(cnt0));
  p_user_filter_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl0[B_NOUSER] && user_mode_i && !cnt0_wr) |=> $stable(cnt0));
  p_hit_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_vec != '0) |=> (pend_q & $past(hit_vec)) == $past(hit_vec));
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0) |=> (pend_q & $past(pend_q & ~clr_m)) == $past(pend_q & ~clr_m));
  p_irq_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == '0) |-> !irq_o);
  p_snap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sidx0_wr |=> snap_q == $past(cnt0));
endmodule

bind evc_bank evc_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .user_mode_i (user_mode_i),
  .irq_o       (irq_o),
  .pend_q      (pend_q),
  .hit_vec     (hit_vec),
  .inc_vec     (inc_vec),
  .ctrl0       (ctrl_arr[0]),
  .cnt0        (cnt_arr[0]),
  .snap_q      (snap_q)
);

// File: tb/evc_bank_tb_top.sv
`timescale 1ns/1ps
module evc_bank_tb_top;
  localparam int NUM_CNT = 4, CNT_W = 48, NUM_COND = 120;
  localparam logic [9:0] A_CFG = 10'h000, A_SIDX = 10'h001, A_SLO = 10'h002,
                         A_SHI = 10'h003, A_PEND = 10'h004, A_IEN = 10'h005;
  localparam logic [9:0] A0_CTRL = 10'h020, A0_CLO = 10'h021, A0_CHI = 10'h022,
                         A0_LLO = 10'h023, A0_LHI = 10'h024;
  localparam logic [9:0] A1_CTRL = 10'h028, A1_CLO = 10'h029;
  localparam logic [9:0] A_IRQ = 10'h3FF;  // pseudo address: sample irq_o

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, user_mode = 0;
  logic [9:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NUM_COND-1:0] cond = '0;
  logic irq;

  always #2.5 clk = ~clk;

  evc_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .NUM_COND(NUM_COND)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cond_i(cond), .user_mode_i(user_mode), .irq_o(irq));

  typedef struct { logic [9:0] addr; logic [31:0] exp; string req; } item_t;
  item_t sb_q[$];
  int n_checks = 0, n_errors = 0, n_pushed = 0, n_done = 0;

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      item_t it;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      rd_addr = (it.addr == A_IRQ) ? 10'h000 : it.addr;
      #0.5;
      n_checks++;
      if (it.addr == A_IRQ) begin
        if (32'(irq) !== it.exp) begin
          n_errors++;
          $display("FAIL %s irq: actual %0d expected %0d", it.req, irq, it.exp);
        end
      end else if (rd_data !== it.exp) begin
        n_errors++;
        $display("FAIL %s addr %h: actual %h expected %h", it.req, it.addr, rd_data, it.exp);
      end
      n_done++;
    end
  end

  task automatic expect_rd(input logic [9:0] a, input logic [31:0] e, input string r);
    item_t it;
    it.addr = a; it.exp = e; it.req = r;
    sb_q.push_back(it);
    n_pushed++;
    wait (n_done == n_pushed);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(input int bit_n, input int cycles);
    @(negedge clk);
    cond[bit_n] = 1'b1;
    for (int k = 0; k < cycles; k++) @(negedge clk);
    cond[bit_n] = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    @(negedge clk);
    // R1, R9
    expect_rd(A_CFG, {16'd120, 8'd48, 8'd4}, "R9");
    expect_rd(A0_CLO, 32'd0, "R1");
    expect_rd(A0_LLO, 32'd0, "R1");
    expect_rd(A_PEND, 32'd0, "R1");
    expect_rd(A_IRQ, 32'd0, "R1");
    // R2: select condition 5, enabled
    wr(A0_CTRL, 32'h0501);
    expect_rd(A0_CTRL, 32'h0501, "R2");
    pulse(5, 3);
    expect_rd(A0_CLO, 32'd3, "R2");
    pulse(6, 2);
    expect_rd(A0_CLO, 32'd3, "R2");
    wr(A0_CTRL, 32'h0500);
    pulse(5, 2);
    expect_rd(A0_CLO, 32'd3, "R2");
    wr(A0_CTRL, 32'h0501);
    // R3: load, then write collides with an event
    wr(A0_CLO, 32'd100);
    expect_rd(A0_CLO, 32'd100, "R3");
    @(negedge clk);
    cond[5] = 1; wr_en = 1; wr_addr = A0_CLO; wr_data = 32'd7;
    @(negedge clk);
    cond[5] = 0; wr_en = 0;
    expect_rd(A0_CLO, 32'd7, "R3");
    // R4: limit 10
    wr(A0_LLO, 32'd10);
    wr(A_IEN, 32'h1);
    wr(A0_CLO, 32'd8);
    pulse(5, 1);
    expect_rd(A0_CLO, 32'd9, "R4");
    expect_rd(A_PEND, 32'd0, "R4");
    pulse(5, 1);
    expect_rd(A_PEND, 32'h1, "R4");
    expect_rd(A_IRQ, 32'd1, "R6");
    pulse(5, 2);
    expect_rd(A0_CLO, 32'd12, "R4");
    expect_rd(A_PEND, 32'h1, "R4");
    // R6: mask
    wr(A_IEN, 32'h0);
    expect_rd(A_IRQ, 32'd0, "R6");
    wr(A_IEN, 32'h1);
    expect_rd(A_IRQ, 32'd1, "R6");
    // R5
    wr(A_PEND, 32'h0);
    expect_rd(A_PEND, 32'h1, "R5");
    wr(A_PEND, 32'h1);
    expect_rd(A_PEND, 32'h0, "R5");
    expect_rd(A_IRQ, 32'd0, "R5");
    wr(A0_CLO, 32'd9);
    @(negedge clk);
    cond[5] = 1; wr_en = 1; wr_addr = A_PEND; wr_data = 32'h1;
    @(negedge clk);
    cond[5] = 0; wr_en = 0;
    expect_rd(A_PEND, 32'h1, "R5");
    wr(A_PEND, 32'h1);
    // R7
    wr(A0_CLO, 32'd50);
    wr(A0_CTRL, 32'h0503);
    user_mode = 1;
    pulse(5, 1);
    expect_rd(A0_CLO, 32'd50, "R7");
    user_mode = 0;
    pulse(5, 1);
    expect_rd(A0_CLO, 32'd51, "R7");
    wr(A0_CTRL, 32'h0505);
    pulse(5, 1);
    expect_rd(A0_CLO, 32'd51, "R7");
    user_mode = 1;
    pulse(5, 1);
    expect_rd(A0_CLO, 32'd52, "R7");
    user_mode = 0;
    wr(A0_CTRL, 32'h0501);
    // R8
    wr(A0_CLO, 32'h89AB_CDEF);
    wr(A0_CHI, 32'h0000_1234);
    wr(A_SIDX, 32'd0);
    pulse(5, 3);
    expect_rd(A_SLO, 32'h89AB_CDEF, "R8");
    expect_rd(A_SHI, 32'h0000_1234, "R8");
    expect_rd(A0_CLO, 32'h89AB_CDF2, "R8");
    wr(A1_CTRL, 32'h0701);
    pulse(7, 1);
    expect_rd(A1_CLO, 32'd1, "R2");
    expect_rd(A0_CLO, 32'h89AB_CDF2, "R2");
    wr(A_SIDX, 32'd1);
    expect_rd(A_SLO, 32'd1, "R8");
    expect_rd(A_SHI, 32'd0, "R8");
    // R10
    wr(A0_CHI, 32'd0);
    wr(A0_CLO, 32'hFFFF_FFFF);
    pulse(5, 1);
    expect_rd(A0_CLO, 32'd0, "R10");
    expect_rd(A0_CHI, 32'd1, "R10");
    wr(A0_CHI, 32'h0000_FFFF);
    wr(A0_CLO, 32'hFFFF_FFFF);
    pulse(5, 1);
    expect_rd(A0_CLO, 32'd0, "R10");
    expect_rd(A0_CHI, 32'd0, "R10");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule